// File: doc/BRIEF.md
# Frame-Synchronous Time-Slot Interchange with Shadowed Connection Maps

This block switches bytes between a small group of input lanes that share one frame timing. Every lane carries `SLOTS` byte time slots per frame, one byte per clock. The block stores each frame of incoming bytes in a buffer. During the following frame it builds each output byte from that buffer. The input lane and slot for each output slot come from a connection map. The fabric has a single stage and never blocks, so any stored byte can feed any number of output slots.

Two routing maps exist: a service map and a protection map. A control table holds one entry per output slot. Each control entry chooses between the two maps for its slot and can force a fixed path-alarm or unequipped pattern onto that slot. Software updates shadow copies of all three tables through a simple write port. The shadow contents are copied into the live tables only at a frame start, after a swap has been requested. A swap can be requested by a software strobe or by an in-band signal from the line side.

Top module: `tsi_shadow_switch`

## Requirements
- R1: The output byte of output lane o, slot s appears one clock after input slot s of frame k+1 has been presented. Its value is the byte that frame k carried on the input lane and slot named by the live entry for (o, s). Slot s is the s-th clock after the `frameStart` pulse, which marks slot 0.
- R2: One input slot can drive any number of output slots in the same frame, on the same lane or on different lanes.
- R3: A write through the configuration port changes only the shadow tables. Until a swap is applied, the output keeps following the previous live tables.
- R4: A swap request that arrives in a cycle without `frameStart` is held pending. It is applied in the next `frameStart` cycle, so the first output byte of the new frame already uses the new tables.
- R5: Pulsing `swapInband` has the same effect as pulsing `swapCmd`.
- R6: Each output slot's control entry carries a map select bit: 0 uses the service map and 1 uses the protection map. The select bits of different slots are independent.
- R7: The control force code is 2'b01 for a path-alarm slot, which outputs 8'hFF, and 2'b10 for an unequipped slot, which outputs 8'h00. Either code overrides the map lookup. Codes 2'b00 and 2'b11 leave the slot routed normally.
- R8: After reset, `outData` is all zeros, no swap is pending, and every live and shadow entry is zero: lane 0, slot 0, service map, no forcing.
- R9: The `cfgTarget` field selects the table: 0 is the service map, 1 is the protection map, 2 is the control table, and 3 selects nothing. A write with target 3 has no effect on any table.
- R10: A swap request in the same cycle as `frameStart` is applied in that cycle, not one frame later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | Pulse marking input slot 0 of every frame |
| inData | input | LANES*8 | One input byte per lane; lane l is in bits [8l+7:8l] |
| cfgWe | input | 1 | Shadow table write strobe |
| cfgTarget | input | 2 | Table select: 0 service, 1 protection, 2 control, 3 none |
| cfgOutLane | input | LW | Output lane of the entry being written |
| cfgOutSlot | input | SW | Output slot of the entry being written |
| cfgSrcLane | input | LW | Source input lane (map targets) |
| cfgSrcSlot | input | SW | Source input slot (map targets) |
| cfgProt | input | 1 | Map select bit (control target) |
| cfgForce | input | 2 | Force code (control target) |
| swapCmd | input | 1 | Software swap request |
| swapInband | input | 1 | In-band swap request |
| outData | output | LANES*8 | One output byte per lane, registered |

## Verification
The hardest case to reach is the boundary of a table swap. A request must stay pending across the last slots of a frame, and a request that coincides with `frameStart` must take effect in that same cycle. Shadow writes can also arrive while a request is still pending. The stimulus places each swap request at a chosen slot offset. Shadow writes are streamed one per clock across frame edges, so some of them land after the request but before the swap. A reference model compares every output byte of the frames on either side of each swap.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

  typedef struct packed {
    logic wrBank;
    logic rdBank;
    logic applySwap;
  } tsi_strobe_t;

  typedef enum logic [1:0] {
    TGT_SVC  = 2'd0,
    TGT_PROT = 2'd1,
    TGT_CTRL = 2'd2,
    TGT_NONE = 2'd3
  } cfg_target_e;

  localparam logic [1:0] FORCE_AIS  = 2'b01;
  localparam logic [1:0] FORCE_UNEQ = 2'b10;

endpackage

// File: rtl/tsi_ctrl.sv
module tsi_ctrl
  import tsi_pkg::*;
#(
  parameter int SLOTS = 4,
  localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frameStart,
  input  logic          swapCmd,
  input  logic          swapInband,
  output tsi_strobe_t   strobe,
  output logic [SW-1:0] curSlot
);

  logic [SW-1:0] slotCnt;
  logic          bankReg;
  logic          pendReg;
  logic          wrBank;
  logic          anyReq;
  logic          applySwap;

  assign anyReq    = swapCmd | swapInband;
  assign curSlot   = frameStart ? '0 : slotCnt;
  assign wrBank    = frameStart ? ~bankReg : bankReg;
  assign applySwap = frameStart & (pendReg | anyReq);

  assign strobe.wrBank    = wrBank;
  assign strobe.rdBank    = ~wrBank;
  assign strobe.applySwap = applySwap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slotCnt <= '0;
      bankReg <= 1'b0;
      pendReg <= 1'b0;
    end else begin
      slotCnt <= (curSlot == SW'(SLOTS - 1)) ? '0 : curSlot + SW'(1);
      bankReg <= wrBank;
      if (applySwap)   pendReg <= 1'b0;
      else if (anyReq) pendReg <= 1'b1;
    end
  end

  assert_slot_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
    frameStart |=> slotCnt == SW'(1));

  assert_bank_flip_R1: assert property (@(posedge clk) disable iff (!rst_n)
    frameStart |=> bankReg != $past(bankReg));

  assert_swap_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (anyReq && !frameStart) |=> pendReg);

  assert_pend_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    applySwap |=> !pendReg);

endmodule

// File: rtl/tsi_datapath.sv
module tsi_datapath
  import tsi_pkg::*;
#(
  parameter int LANES = 2,
  parameter int SLOTS = 4,
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int ENTRIES = LANES * SLOTS,
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int EW = LW + SW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  tsi_strobe_t        strobe,
  input  logic [SW-1:0]      curSlot,
  input  logic [LANES*8-1:0] inData,
  input  logic               cfgWe,
  input  logic [1:0]         cfgTarget,
  input  logic [LW-1:0]      cfgOutLane,
  input  logic [SW-1:0]      cfgOutSlot,
  input  logic [LW-1:0]      cfgSrcLane,
  input  logic [SW-1:0]      cfgSrcSlot,
  input  logic               cfgProt,
  input  logic [1:0]         cfgForce,
  output logic [LANES*8-1:0] outData
);

  logic [ENTRIES-1:0][EW-1:0] shSvc, acSvc, shProt, acProt;
  logic [ENTRIES-1:0][2:0]    shCtl, acCtl;
  logic [7:0] dataBuf [2][LANES][SLOTS];
  logic [IW-1:0] cfgIdx;

  assign cfgIdx = IW'(cfgOutLane) * IW'(SLOTS) + IW'(cfgOutSlot);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shSvc <= '0; acSvc <= '0;
      shProt <= '0; acProt <= '0;
      shCtl <= '0; acCtl <= '0;
    end else begin
      if (strobe.applySwap) begin
        acSvc  <= shSvc;
        acProt <= shProt;
        acCtl  <= shCtl;
      end
      if (cfgWe) begin
        case (cfg_target_e'(cfgTarget))
          TGT_SVC:  shSvc[cfgIdx]  <= {cfgSrcLane, cfgSrcSlot};
          TGT_PROT: shProt[cfgIdx] <= {cfgSrcLane, cfgSrcSlot};
          TGT_CTRL: shCtl[cfgIdx]  <= {cfgForce, cfgProt};
          default:  ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++)
      dataBuf[strobe.wrBank][l][curSlot] <= inData[l*8 +: 8];
  end

  for (genvar o = 0; o < LANES; o++) begin : g_out
    logic [IW-1:0]  rowIdx;
    logic [2:0]     ctl;
    logic [EW-1:0]  svcEnt, protEnt, src;
    logic [7:0]     nextByte;
    logic [7:0]     outReg;

    assign rowIdx  = IW'(o * SLOTS) + IW'(curSlot);
    assign ctl     = strobe.applySwap ? shCtl[rowIdx]  : acCtl[rowIdx];
    assign svcEnt  = strobe.applySwap ? shSvc[rowIdx]  : acSvc[rowIdx];
    assign protEnt = strobe.applySwap ? shProt[rowIdx] : acProt[rowIdx];
    assign src     = ctl[0] ? protEnt : svcEnt;

    always_comb begin
      case (ctl[2:1])
        FORCE_AIS:  nextByte = 8'hFF;
        FORCE_UNEQ: nextByte = 8'h00;
        default:    nextByte = dataBuf[strobe.rdBank][src[EW-1:SW]][src[SW-1:0]];
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rst_n) outReg <= '0;
      else        outReg <= nextByte;
    end

    assign outData[o*8 +: 8] = outReg;
  end

  assert_swap_copies_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.applySwap |=> (acSvc == $past(shSvc)) && (acProt == $past(shProt))
                         && (acCtl == $past(shCtl)));

  assert_live_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.applySwap |=> $stable(acSvc) && $stable(acProt) && $stable(acCtl));

endmodule

// File: rtl/tsi_shadow_switch.sv
module tsi_shadow_switch
  import tsi_pkg::*;
#(
  parameter int LANES = 2,
  parameter int SLOTS = 4,
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frameStart,
  input  logic [LANES*8-1:0] inData,
  input  logic               cfgWe,
  input  logic [1:0]         cfgTarget,
  input  logic [LW-1:0]      cfgOutLane,
  input  logic [SW-1:0]      cfgOutSlot,
  input  logic [LW-1:0]      cfgSrcLane,
  input  logic [SW-1:0]      cfgSrcSlot,
  input  logic               cfgProt,
  input  logic [1:0]         cfgForce,
  input  logic               swapCmd,
  input  logic               swapInband,
  output logic [LANES*8-1:0] outData
);

  tsi_strobe_t   strobe;
  logic [SW-1:0] curSlot;

  tsi_ctrl #(.SLOTS(SLOTS)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .frameStart(frameStart),
    .swapCmd(swapCmd), .swapInband(swapInband),
    .strobe(strobe), .curSlot(curSlot)
  );

  tsi_datapath #(.LANES(LANES), .SLOTS(SLOTS)) i_datapath (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .curSlot(curSlot),
    .inData(inData), .cfgWe(cfgWe), .cfgTarget(cfgTarget),
    .cfgOutLane(cfgOutLane), .cfgOutSlot(cfgOutSlot),
    .cfgSrcLane(cfgSrcLane), .cfgSrcSlot(cfgSrcSlot),
    .cfgProt(cfgProt), .cfgForce(cfgForce), .outData(outData)
  );

endmodule

// File: tb/test_tsi_shadow_switch.sv
module test_tsi_shadow_switch;

  localparam int LANES = 2;
  localparam int SLOTS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frameStart = 1'b0;
  logic [LANES*8-1:0] inData = '0;
  logic cfgWe = 1'b0;
  logic [1:0] cfgTarget = '0;
  logic [0:0] cfgOutLane = '0, cfgSrcLane = '0;
  logic [1:0] cfgOutSlot = '0, cfgSrcSlot = '0;
  logic cfgProt = 1'b0;
  logic [1:0] cfgForce = '0;
  logic swapCmd = 1'b0, swapInband = 1'b0;
  logic [LANES*8-1:0] outData;

  tsi_shadow_switch #(.LANES(LANES), .SLOTS(SLOTS)) i_tsi_shadow_switch (
    .clk(clk), .rst_n(rst_n), .frameStart(frameStart), .inData(inData),
    .cfgWe(cfgWe), .cfgTarget(cfgTarget), .cfgOutLane(cfgOutLane),
    .cfgOutSlot(cfgOutSlot), .cfgSrcLane(cfgSrcLane), .cfgSrcSlot(cfgSrcSlot),
    .cfgProt(cfgProt), .cfgForce(cfgForce), .swapCmd(swapCmd),
    .swapInband(swapInband), .outData(outData)
  );

  always #2.5 clk = ~clk;

  typedef struct { int sl; int ss; int pl; int ps; int p; int f; } ent_t;
  typedef struct { int tgt; int ol; int os; int sl; int ss; int p; int f; } cfg_t;
  typedef struct { bit chk; logic [LANES*8-1:0] exp; string tag; } item_t;

  ent_t sh [LANES][SLOTS];
  ent_t ac [LANES][SLOTS];
  logic [7:0] prevF [LANES][SLOTS];
  logic [7:0] curF [LANES][SLOTS];
  bit pend = 0;
  int frameNo = 0;
  cfg_t cfgQ[$];
  item_t sbq[$];
  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  task automatic queueCfg(int tgt, int ol, int os, int sl, int ss, int p, int f);
    cfg_t c;
    c.tgt = tgt; c.ol = ol; c.os = os; c.sl = sl; c.ss = ss; c.p = p; c.f = f;
    cfgQ.push_back(c);
  endtask

  task automatic runFrame(int swapAt, bit inband, string tag);
    for (int s = 0; s < SLOTS; s++) begin
      item_t it;
      cfg_t c;
      bit haveCfg;
      @(negedge clk);
      frameStart = (s == 0);
      swapCmd = (s == swapAt) && !inband;
      swapInband = (s == swapAt) && inband;
      for (int l = 0; l < LANES; l++)
        inData[l*8 +: 8] = 8'((frameNo * 29 + l * 7 + s * 3 + 1) & 255);
      haveCfg = (cfgQ.size() > 0);
      if (haveCfg) begin
        c = cfgQ.pop_front();
        cfgWe = 1'b1; cfgTarget = 2'(c.tgt); cfgOutLane = 1'(c.ol);
        cfgOutSlot = 2'(c.os); cfgSrcLane = 1'(c.sl); cfgSrcSlot = 2'(c.ss);
        cfgProt = 1'(c.p); cfgForce = 2'(c.f);
      end else cfgWe = 1'b0;
      if (s == 0) begin
        if (pend || swapAt == 0) begin
          for (int o = 0; o < LANES; o++)
            for (int k = 0; k < SLOTS; k++) ac[o][k] = sh[o][k];
          pend = 0;
        end
        for (int o = 0; o < LANES; o++)
          for (int k = 0; k < SLOTS; k++) prevF[o][k] = curF[o][k];
      end else if (swapAt == s) pend = 1;
      it.chk = (frameNo >= 1);
      it.tag = tag;
      for (int o = 0; o < LANES; o++) begin
        ent_t e;
        e = ac[o][s];
        if (e.f == 1) it.exp[o*8 +: 8] = 8'hFF;
        else if (e.f == 2) it.exp[o*8 +: 8] = 8'h00;
        else if (e.p == 1) it.exp[o*8 +: 8] = prevF[e.pl][e.ps];
        else it.exp[o*8 +: 8] = prevF[e.sl][e.ss];
      end
      for (int l = 0; l < LANES; l++) curF[l][s] = inData[l*8 +: 8];
      if (haveCfg) begin
        case (c.tgt)
          0: begin sh[c.ol][c.os].sl = c.sl; sh[c.ol][c.os].ss = c.ss; end
          1: begin sh[c.ol][c.os].pl = c.sl; sh[c.ol][c.os].ps = c.ss; end
          2: begin sh[c.ol][c.os].p = c.p; sh[c.ol][c.os].f = c.f; end
          default: ;
        endcase
      end
      @(posedge clk);
      sbq.push_back(it);
    end
    frameNo++;
  endtask

  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      if (it.chk) begin
        for (int o = 0; o < LANES; o++) begin
          nChecks++;
          if (outData[o*8 +: 8] !== it.exp[o*8 +: 8]) begin
            nFail++;
            $display("FAIL %s lane %0d: actual %h expected %h", it.tag, o,
                     outData[o*8 +: 8], it.exp[o*8 +: 8]);
          end
        end
      end
    end
  end

  initial begin
    for (int o = 0; o < LANES; o++)
      for (int k = 0; k < SLOTS; k++) begin
        sh[o][k] = '{0, 0, 0, 0, 0, 0};
        ac[o][k] = '{0, 0, 0, 0, 0, 0};
        curF[o][k] = '0;
      end
    repeat (3) @(posedge clk);
    @(negedge clk);
    nChecks++;
    if (outData !== '0) begin
      nFail++;
      $display("FAIL R8 reset output: actual %h expected %h", outData, 16'h0);
    end
    rst_n = 1'b1;

    runFrame(-1, 0, "R8 R1 warmup");
    runFrame(-1, 0, "R8 R1 reset map");
    // cross map: out (o,s) <- in (1-o, 3-s)
    for (int o = 0; o < LANES; o++)
      for (int k = 0; k < SLOTS; k++) queueCfg(0, o, k, 1 - o, 3 - k, 0, 0);
    runFrame(-1, 0, "R3 shadow write no swap");
    runFrame(3, 0, "R3 request pending");
    runFrame(-1, 0, "R4 R1 new map at slot 0");
    runFrame(-1, 0, "R1 steady");
    // multicast: lane0 all from (0,1), lane1 slots 0,2 from (0,1)
    for (int k = 0; k < SLOTS; k++) queueCfg(0, 0, k, 0, 1, 0, 0);
    queueCfg(0, 1, 0, 0, 1, 0, 0);
    queueCfg(0, 1, 2, 0, 1, 0, 0);
    runFrame(-1, 0, "R3 multicast shadow");
    runFrame(1, 1, "R5 inband request");
    runFrame(-1, 0, "R2 R5 multicast live");
    // protection map on lane1 plus per-slot selects
    for (int k = 0; k < SLOTS; k++) queueCfg(1, 1, k, 0, k, 0, 0);
    queueCfg(2, 1, 1, 0, 0, 1, 0);
    queueCfg(2, 1, 3, 0, 0, 1, 0);
    runFrame(-1, 0, "R3 protection shadow");
    runFrame(-1, 0, "R3 protection shadow");
    runFrame(0, 0, "R10 R6 swap at frame start");
    runFrame(-1, 0, "R6 mixed selects");
    // forcing
    queueCfg(2, 0, 0, 0, 0, 0, 1);
    queueCfg(2, 0, 1, 0, 0, 0, 2);
    queueCfg(2, 0, 2, 0, 0, 0, 3);
    queueCfg(2, 1, 2, 0, 0, 1, 1);
    runFrame(2, 0, "R3 force shadow");
    runFrame(-1, 0, "R7 forced slots");
    runFrame(-1, 0, "R7 forced slots");
    // target 3 writes must not land anywhere
    queueCfg(3, 0, 0, 1, 2, 1, 2);
    queueCfg(3, 1, 1, 1, 0, 0, 1);
    queueCfg(3, 0, 3, 0, 0, 1, 2);
    runFrame(3, 0, "R9 ignored target");
    runFrame(-1, 0, "R9 ignored target");
    @(negedge clk);
    frameStart = 1'b0; cfgWe = 1'b0; swapCmd = 1'b0; swapInband = 1'b0;
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

endmodule